// File: doc/BRIEF.md
# Iambic Morse Paddle Keyer with Element Memory

This block turns a two-lever Morse paddle into correctly timed dots and dashes. A dot lasts one unit, a dash lasts three units, and every element is followed by a gap of one unit. The unit length comes from a programmable divider of the system clock. Its count is loaded from an 8-bit speed value, so one unit is `(speed_i + 1) * UNIT_SCALE` clock cycles. The divider runs only while the keyer is active and restarts from zero when a paddle closes, so the first element starts with no random phase delay.

Once an element starts, it always runs to its full length. Pressing the opposite lever during an element stores a request, and the stored element is sent after the gap. When both levers are held, dots and dashes alternate. The keyed output drives a transmitter relay. A square-wave sidetone for a speaker is gated by that output.

Top module: `paddle_keyer`

## Requirements
- R1: After reset, and while no paddle is pressed, `key_o` and `tone_o` stay low.
- R2: A dot holds `key_o` high for exactly U clock cycles, where U = (speed_i + 1) * UNIT_SCALE.
- R3: A dash holds `key_o` high for exactly 3U clock cycles.
- R4: Between two consecutive elements, `key_o` is low for exactly U cycles, whatever the paddles do.
- R5: An element that has started runs to its full length even if its paddle is released at once.
- R6: A dot paddle pressed and released during a dash makes one dot follow the dash, after a U-cycle gap.
- R7: A dash paddle pressed and released during a dot makes one dash follow the dot, after a U-cycle gap.
- R8: With both paddles held, dots and dashes alternate, and each new element is the opposite of the last one sent. After reset the last element counts as a dash, so a dot comes first.
- R9: A stored request is cleared when its element starts, so a single tap produces exactly one element.
- R10: `tone_o` is high only while `key_o` is high. Within a mark, in key-high cycle i (counting from 0), `tone_o` equals bit 0 of i / TONE_HALF.
- R11: From idle, paddle inputs pass through a two-flop synchroniser. A press applied before a clock edge raises `key_o` after the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_paddle_i | input | 1 | Dot lever, active high, asynchronous |
| dash_paddle_i | input | 1 | Dash lever, active high, asynchronous |
| speed_i | input | SPEED_W | Unit length selector; one unit is (speed_i+1)*UNIT_SCALE clocks |
| key_o | output | 1 | Keyed output, high during a mark |
| tone_o | output | 1 | Sidetone square wave, gated by key_o |

## Verification
The assertions on mark length and gap length compute U from the current `speed_i`. They therefore assume that `speed_i` stays constant from the first press of a sequence until the keyer has gone idle again. The stimulus changes the speed only after a long quiet period, once the last gap has ended. The paddles are assumed to be free of contact bounce. The stimulus drives clean levels on falling clock edges and holds each tap long enough to pass the synchroniser while the target element is still marking.

// File: rtl/keyer_pkg.sv
package keyer_pkg;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_MARK  = 2'd1,
      KS_SPACE = 2'd2
   } kstate_t;

   typedef enum logic {
      EL_DOT  = 1'b0,
      EL_DASH = 1'b1
   } elem_t;

   localparam int LEVER_DOT  = 0;
   localparam int LEVER_DASH = 1;
   localparam int LEVERS     = 2;

endpackage

// File: rtl/keyer_sync.sv
module keyer_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain <= {chain[STAGES-2:0], async_i[b]};
         end
      end

      assign sync_o[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/keyer_unit_timer.sv
module keyer_unit_timer #(
   parameter int SPEED_W    = 8,
   parameter int UNIT_SCALE = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic [SPEED_W-1:0] speed_i,
   output logic               tick_o
);

   localparam int CW = SPEED_W + $clog2(UNIT_SCALE + 1) + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] unit_last;

   assign unit_last = (CW'(speed_i) + CW'(1)) * CW'(UNIT_SCALE) - CW'(1);
   assign tick_o    = run_i && (cnt >= unit_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run_i || tick_o) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/keyer_seq.sv
module keyer_seq
   import keyer_pkg::*;
#(
   parameter int DOT_UNITS  = 1,
   parameter int DASH_UNITS = 3,
   parameter int GAP_UNITS  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dot_req_i,
   input  logic dash_req_i,
   input  logic tick_i,
   output logic run_o,
   output logic key_o
);

   localparam int MAXE = (DASH_UNITS > DOT_UNITS) ? DASH_UNITS : DOT_UNITS;
   localparam int MAXA = (MAXE > GAP_UNITS) ? MAXE : GAP_UNITS;
   localparam int LW   = $clog2(MAXA + 1);
   localparam logic [LW-1:0] DOT_LAST  = LW'(DOT_UNITS - 1);
   localparam logic [LW-1:0] DASH_LAST = LW'(DASH_UNITS - 1);
   localparam logic [LW-1:0] GAP_LAST  = LW'(GAP_UNITS - 1);

   kstate_t       state;
   elem_t         last_el;
   elem_t         pick;
   logic [LW-1:0] left;
   logic          mem_dot;
   logic          mem_dash;
   logic          want_dot;
   logic          want_dash;
   logic          any_want;
   logic [LW-1:0] pick_last;

   assign want_dot  = dot_req_i | mem_dot;
   assign want_dash = dash_req_i | mem_dash;
   assign any_want  = want_dot | want_dash;

   always_comb begin
      if (want_dot && want_dash) begin
         pick = (last_el == EL_DOT) ? EL_DASH : EL_DOT;
      end else if (want_dash) begin
         pick = EL_DASH;
      end else begin
         pick = EL_DOT;
      end
      pick_last = (pick == EL_DOT) ? DOT_LAST : DASH_LAST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= KS_IDLE;
         last_el  <= EL_DASH;
         left     <= '0;
         mem_dot  <= 1'b0;
         mem_dash <= 1'b0;
      end else begin
         unique case (state)
            KS_IDLE: begin
               if (any_want) begin
                  state   <= KS_MARK;
                  last_el <= pick;
                  left    <= pick_last;
                  if (pick == EL_DOT) mem_dot  <= 1'b0;
                  else                mem_dash <= 1'b0;
               end
            end
            KS_MARK: begin
               if (last_el == EL_DASH && dot_req_i) mem_dot  <= 1'b1;
               if (last_el == EL_DOT && dash_req_i) mem_dash <= 1'b1;
               if (tick_i) begin
                  if (left == '0) begin
                     state <= KS_SPACE;
                     left  <= GAP_LAST;
                  end else begin
                     left <= left - LW'(1);
                  end
               end
            end
            KS_SPACE: begin
               if (tick_i) begin
                  if (left != '0) begin
                     left <= left - LW'(1);
                  end else if (any_want) begin
                     state   <= KS_MARK;
                     last_el <= pick;
                     left    <= pick_last;
                     if (pick == EL_DOT) mem_dot  <= 1'b0;
                     else                mem_dash <= 1'b0;
                  end else begin
                     state <= KS_IDLE;
                  end
               end
            end
            default: state <= KS_IDLE;
         endcase
      end
   end

   assign run_o = (state != KS_IDLE);
   assign key_o = (state == KS_MARK);

endmodule

// File: rtl/keyer_tone.sv
module keyer_tone #(
   parameter int TONE_HALF = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_i,
   output logic tone_o
);

   localparam int TW = $clog2(TONE_HALF + 1);
   localparam logic [TW-1:0] HALF_LAST = TW'(TONE_HALF - 1);

   logic [TW-1:0] cnt;
   logic          phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!key_i) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (cnt == HALF_LAST) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt <= cnt + TW'(1);
      end
   end

   assign tone_o = key_i & phase;

endmodule

// File: rtl/paddle_keyer.sv
module paddle_keyer
   import keyer_pkg::*;
#(
   parameter int SPEED_W     = 8,
   parameter int UNIT_SCALE  = 1000,
   parameter int DOT_UNITS   = 1,
   parameter int DASH_UNITS  = 3,
   parameter int GAP_UNITS   = 1,
   parameter int SYNC_STAGES = 2,
   parameter int TONE_HALF   = 25000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dot_paddle_i,
   input  logic               dash_paddle_i,
   input  logic [SPEED_W-1:0] speed_i,
   output logic               key_o,
   output logic               tone_o
);

   if (SPEED_W < 1 || SPEED_W > 16) begin : g_bad_speed_w
      $error("paddle_keyer: SPEED_W must lie in 1..16");
   end
   if (UNIT_SCALE < 1) begin : g_bad_scale
      $error("paddle_keyer: UNIT_SCALE must be at least 1");
   end
   if (DOT_UNITS < 1 || DASH_UNITS <= DOT_UNITS) begin : g_bad_elem
      $error("paddle_keyer: need 1 <= DOT_UNITS < DASH_UNITS");
   end
   if (GAP_UNITS < 1) begin : g_bad_gap
      $error("paddle_keyer: GAP_UNITS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("paddle_keyer: SYNC_STAGES must be at least 2");
   end
   if (TONE_HALF < 1) begin : g_bad_tone
      $error("paddle_keyer: TONE_HALF must be at least 1");
   end

   logic [LEVERS-1:0] lever_raw;
   logic [LEVERS-1:0] lever_s;
   logic              run;
   logic              tick;
   logic              key;

   assign lever_raw[LEVER_DOT]  = dot_paddle_i;
   assign lever_raw[LEVER_DASH] = dash_paddle_i;

   keyer_sync #(
      .WIDTH  (LEVERS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (lever_raw),
      .sync_o  (lever_s)
   );

   keyer_unit_timer #(
      .SPEED_W    (SPEED_W),
      .UNIT_SCALE (UNIT_SCALE)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .speed_i (speed_i),
      .tick_o  (tick)
   );

   keyer_seq #(
      .DOT_UNITS  (DOT_UNITS),
      .DASH_UNITS (DASH_UNITS),
      .GAP_UNITS  (GAP_UNITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .dot_req_i  (lever_s[LEVER_DOT]),
      .dash_req_i (lever_s[LEVER_DASH]),
      .tick_i     (tick),
      .run_o      (run),
      .key_o      (key)
   );

   keyer_tone #(
      .TONE_HALF (TONE_HALF)
   ) u_tone (
      .clk    (clk),
      .rst_n  (rst_n),
      .key_i  (key),
      .tone_o (tone_o)
   );

   assign key_o = key;

endmodule

// File: rtl/paddle_keyer_chk.sv
module paddle_keyer_chk #(
   parameter int SPEED_W    = 8,
   parameter int UNIT_SCALE = 1000,
   parameter int DOT_UNITS  = 1,
   parameter int DASH_UNITS = 3,
   parameter int GAP_UNITS  = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [SPEED_W-1:0] speed_i,
   input logic               key_o,
   input logic               tone_o
);

   int   unit_len;
   int   mark_cnt;
   int   low_cnt;
   logic seen_fall;

   assign unit_len = (int'(speed_i) + 1) * UNIT_SCALE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_cnt  <= 0;
         low_cnt   <= 0;
         seen_fall <= 1'b0;
      end else begin
         mark_cnt <= key_o ? mark_cnt + 1 : 0;
         low_cnt  <= key_o ? 0 : low_cnt + 1;
         if (!key_o && mark_cnt != 0) seen_fall <= 1'b1;
      end
   end

   // R10: no sidetone without key
   p_tone_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !key_o |-> !tone_o);

   // R10: tone moves only during a mark or as the mark ends
   p_tone_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tone_o) |-> (key_o || $past(key_o)));

   // R2 and R3: a finished mark is one dot or one dash long
   p_mark_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(key_o) |-> (mark_cnt == DOT_UNITS * unit_len ||
                        mark_cnt == DASH_UNITS * unit_len));

   // R4: spacing before a new mark is never shorter than the gap
   p_gap_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(key_o) && seen_fall) |-> (low_cnt >= GAP_UNITS * unit_len));

endmodule

bind paddle_keyer paddle_keyer_chk #(
   .SPEED_W    (SPEED_W),
   .UNIT_SCALE (UNIT_SCALE),
   .DOT_UNITS  (DOT_UNITS),
   .DASH_UNITS (DASH_UNITS),
   .GAP_UNITS  (GAP_UNITS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .speed_i (speed_i),
   .key_o   (key_o),
   .tone_o  (tone_o)
);

// File: tb/paddle_keyer_bench.sv
module paddle_keyer_bench;

   localparam int SW    = 8;
   localparam int SCALE = 2;
   localparam int HALF  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dot = 1'b0;
   logic          dash = 1'b0;
   logic [SW-1:0] speed = '0;
   logic          key_o;
   logic          tone_o;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   paddle_keyer #(
      .SPEED_W    (SW),
      .UNIT_SCALE (SCALE),
      .TONE_HALF  (HALF)
   ) u_paddle_keyer (
      .clk           (clk),
      .rst_n         (rst_n),
      .dot_paddle_i  (dot),
      .dash_paddle_i (dash),
      .speed_i       (speed),
      .key_o         (key_o),
      .tone_o        (tone_o)
   );

   always #4 clk = ~clk;

   // monitor of mark and gap lengths, sampled on falling edges
   int marks[16];
   int gaps[16];
   int thigh[16];
   int nm = 0, ng = 0, hcnt = 0, lcnt = 0, tcnt = 0, tone_bad = 0;
   bit prev_key = 1'b0, had_mark = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (key_o) begin
            if (!prev_key) begin
               if (had_mark && ng < 16) begin gaps[ng] = lcnt; ng++; end
               hcnt = 0; tcnt = 0;
            end
            hcnt++;
            if (tone_o) tcnt++;
         end else begin
            if (prev_key && nm < 16) begin
               marks[nm] = hcnt; thigh[nm] = tcnt; nm++;
               had_mark = 1'b1; lcnt = 0;
            end
            lcnt++;
            if (tone_o) tone_bad++;
         end
         prev_key = key_o;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ulen(input int s);
      return (s + 1) * SCALE;
   endfunction

   function automatic int exp_tone(input int len);
      int n = 0;
      for (int i = 0; i < len; i++) if (((i / HALF) % 2) == 1) n++;
      return n;
   endfunction

   task automatic clear_mon();
      @(posedge clk);
      nm = 0; ng = 0; had_mark = 1'b0;
   endtask

   task automatic wait_quiet(input int s);
      repeat (12 * ulen(s) + 20) @(negedge clk);
   endtask

   task automatic wait_key_high();
      while (!key_o) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      dot = 1'b0; dash = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      speed = SW'(3);
      do_reset();
      // R1: quiet after reset
      check("R1 key after reset", int'(key_o), 0);
      check("R1 tone after reset", int'(tone_o), 0);
      clear_mon();
      repeat (60) @(negedge clk);
      check("R1 no marks while idle", nm, 0);

      // R8: both held from reset gives dot first, then alternation
      clear_mon();
      @(negedge clk);
      dot = 1'b1; dash = 1'b1;
      while (nm < 4) @(negedge clk);
      dot = 1'b0; dash = 1'b0;
      wait_quiet(3);
      check("R8 first is dot", marks[0], ulen(3));
      check("R8 second is dash", marks[1], 3 * ulen(3));
      check("R8 third is dot", marks[2], ulen(3));
      check("R8 fourth is dash", marks[3], 3 * ulen(3));
      for (int g = 0; g < 3; g++) check("R4 gap with both held", gaps[g], ulen(3));

      // R11: synchroniser latency from idle
      clear_mon();
      @(negedge clk);
      dot = 1'b1;
      @(negedge clk);
      check("R11 key low after edge 1", int'(key_o), 0);
      @(negedge clk);
      check("R11 key low after edge 2", int'(key_o), 0);
      @(negedge clk);
      check("R11 key high after edge 3", int'(key_o), 1);
      dot = 1'b0;
      wait_quiet(3);
      check("R5 dot completes after release", marks[0], ulen(3));
      check("R9 single tap one element", nm, 1);

      // R2 R3 R5: speed sweep with short taps
      for (int s = 0; s < 8; s++) begin
         speed = SW'(s);
         wait_quiet(s);
         clear_mon();
         @(negedge clk); dot = 1'b1;
         wait_key_high();
         dot = 1'b0;
         wait_quiet(s);
         check("R2 dot length", marks[0], ulen(s));
         check("R10 tone in dot", thigh[0], exp_tone(ulen(s)));
         clear_mon();
         @(negedge clk); dash = 1'b1;
         wait_key_high();
         dash = 1'b0;
         wait_quiet(s);
         check("R3 dash length", marks[0], 3 * ulen(s));
         check("R5 dash single", nm, 1);
         check("R10 tone in dash", thigh[0], exp_tone(3 * ulen(s)));
      end

      // R6: dot tapped during dash
      speed = SW'(3);
      wait_quiet(3);
      clear_mon();
      @(negedge clk); dash = 1'b1;
      wait_key_high();
      dash = 1'b0;
      repeat (ulen(3)) @(negedge clk);
      dot = 1'b1;
      repeat (3) @(negedge clk);
      dot = 1'b0;
      wait_quiet(3);
      check("R6 marks after dot memory", nm, 2);
      check("R6 first dash", marks[0], 3 * ulen(3));
      check("R6 stored dot", marks[1], ulen(3));
      check("R4 gap before stored dot", gaps[0], ulen(3));

      // R7: dash tapped during dot
      clear_mon();
      @(negedge clk); dot = 1'b1;
      wait_key_high();
      dot = 1'b0;
      @(negedge clk);
      dash = 1'b1;
      repeat (2) @(negedge clk);
      dash = 1'b0;
      wait_quiet(3);
      check("R7 marks after dash memory", nm, 2);
      check("R7 first dot", marks[0], ulen(3));
      check("R7 stored dash", marks[1], 3 * ulen(3));
      check("R4 gap before stored dash", gaps[0], ulen(3));
      check("R9 memory consumed", nm, 2);

      check("R10 tone never without key", tone_bad, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule